// File: doc/BRIEF.md
# Power Domain Switch Sequencer

This block controls power gating for one switchable logic domain. It runs from a reference oscillator clock and has one 32-bit control and status register. Firmware sets three wait exponents and a collapse bit. An optional hardware request can take the place of the collapse bit. A sequencer then brings the domain down or back up in a fixed order. The outputs are a clock-gate enable, two power-switch enables, an isolation clamp and a domain reset. The "few" switch group is the small first group and carries inrush. The "rest" group is the remainder.

Each timed step lasts exactly 2^n reference cycles, where n is a 4-bit exponent taken from the register. When the domain is restored, its clocks come back a fixed number of cycles after the release of isolation. A software override bypasses the sequencer and applies the requested on or off state directly. A request that arrives while a sequence is running is not lost. It waits as a level until the sequencer reaches the fully-on or fully-off state.

Top module: `pwr_domain_seq`

## Requirements
- R1: After reset the register reads 0x8000_0000. The outputs show the powered-on pattern: clk_en=1, few_en=1, rest_en=1, iso_en=0, dom_rst=0, pwr_on=1.
- R2: The register layout is as follows. Bit 0 is the collapse request. Bit 1 selects hardware control. Bit 2 is the override. The clock-gate wait exponent is at bits 15:12, the few-switch exponent at 19:16 and the rest-switch exponent at 23:20. Bit 31 is the read-only power status. All other bits read 0.
- R3: A collapse runs in this order. First clk_en drops for 2^clk cycles. Then iso_en and dom_rst are raised for 2^rest cycles. Then rest_en drops for 2^few cycles. Then few_en drops, and the domain is off.
- R4: A restore runs in this order. First few_en rises for 2^few cycles. Then rest_en rises for 2^rest cycles. Then iso_en and dom_rst are released for a fixed 4 cycles. Then clk_en rises and the domain is on.
- R5: Every timed step lasts exactly 2^n cycles for any n from 0 to 15.
- R6: pwr_on and register bit 31 are 1 only in the fully-on state. They are 0 during both sequences and while the domain is off.
- R7: A register write takes effect one cycle after the write edge. A change of hw_req takes effect at the first edge that samples it.
- R8: With hardware control set, hw_req=1 requests collapse and hw_req=0 requests restore. The register collapse bit has no effect in this mode.
- R9: A request that reverses direction during a sequence does not interrupt that sequence. It is acted on after one cycle in the stable state that the sequence reaches.
- R10: With the override set, the outputs and the status follow the collapse bit at once. When the override is cleared, the sequencer resumes from the matching stable state and runs no sequence.
- R11: rest_en is never 1 while few_en is 0. clk_en is 1 only when both switch groups are on and isolation and reset are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read value, including status at bit 31 |
| hw_req | input | 1 | Hardware collapse request, used when hardware control is set |
| clk_en | output | 1 | Domain clock enable |
| few_en | output | 1 | Enable for the first (small) switch group |
| rest_en | output | 1 | Enable for the remaining switch group |
| iso_en | output | 1 | Isolation clamp enable |
| dom_rst | output | 1 | Domain reset, active high |
| pwr_on | output | 1 | Domain fully powered and released |

## Verification
The bound checker watches the safety relations on every cycle. It checks that rest_en never stands without few_en, that clk_en appears only on a fully restored domain, and that pwr_on implies that state. It also checks that isolation rises only after the clocks are already gated, that few_en falls only after rest_en is already off, and that clk_en rises only after isolation has been released. The exact length of each step for a given exponent can be shown only by the bench's scenarios. The same holds for the cycle in which a write or hw_req takes effect, for a reversed request being deferred, for the collapse bit being ignored under hardware control, and for the override taking effect at once.

// File: rtl/pds_pkg.sv
package pds_pkg;

   localparam int unsigned FLD_W        = 4;
   localparam int unsigned POS_COLLAPSE = 0;
   localparam int unsigned POS_HWSEL    = 1;
   localparam int unsigned POS_OVR      = 2;
   localparam int unsigned POS_CLKWAIT  = 12;
   localparam int unsigned POS_FEWWAIT  = 16;
   localparam int unsigned POS_RESTWAIT = 20;
   localparam int unsigned POS_STATUS   = 31;

   typedef enum logic [2:0] {
      ST_ON      = 3'd0,
      ST_CLKOFF  = 3'd1,
      ST_ISO     = 3'd2,
      ST_RESTOFF = 3'd3,
      ST_OFF     = 3'd4,
      ST_FEWON   = 3'd5,
      ST_RESTON  = 3'd6,
      ST_RELEASE = 3'd7
   } pds_state_e;

   typedef struct packed {
      logic clk_en;
      logic few_en;
      logic rest_en;
      logic iso_en;
      logic dom_rst;
   } pds_drive_t;

   localparam pds_drive_t DRV_ON  = 5'b11100;
   localparam pds_drive_t DRV_OFF = 5'b00011;

   function automatic pds_drive_t pds_decode(input pds_state_e s);
      case (s)
         ST_ON:      return 5'b11100;
         ST_CLKOFF:  return 5'b01100;
         ST_ISO:     return 5'b01111;
         ST_RESTOFF: return 5'b01011;
         ST_OFF:     return 5'b00011;
         ST_FEWON:   return 5'b01011;
         ST_RESTON:  return 5'b01111;
         default:    return 5'b01100;
      endcase
   endfunction

endpackage

// File: rtl/pds_regs.sv
module pds_regs #(
   parameter int unsigned EXP_W = 4,
   parameter int unsigned REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             status,
   output logic [REG_W-1:0] rd_data,
   output logic             collapse,
   output logic             hw_sel,
   output logic             ovr,
   output logic [EXP_W-1:0] exp_clk,
   output logic [EXP_W-1:0] exp_few,
   output logic [EXP_W-1:0] exp_rest
);
   import pds_pkg::*;

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         collapse <= 1'b0;
         hw_sel   <= 1'b0;
         ovr      <= 1'b0;
         exp_clk  <= '0;
         exp_few  <= '0;
         exp_rest <= '0;
      end else if (wr_en) begin
         collapse <= wr_data[POS_COLLAPSE];
         hw_sel   <= wr_data[POS_HWSEL];
         ovr      <= wr_data[POS_OVR];
         exp_clk  <= wr_data[POS_CLKWAIT  +: EXP_W];
         exp_few  <= wr_data[POS_FEWWAIT  +: EXP_W];
         exp_rest <= wr_data[POS_RESTWAIT +: EXP_W];
      end
   end

   always_comb begin
      rd_data                         = '0;
      rd_data[POS_COLLAPSE]           = collapse;
      rd_data[POS_HWSEL]              = hw_sel;
      rd_data[POS_OVR]                = ovr;
      rd_data[POS_CLKWAIT  +: EXP_W]  = exp_clk;
      rd_data[POS_FEWWAIT  +: EXP_W]  = exp_few;
      rd_data[POS_RESTWAIT +: EXP_W]  = exp_rest;
      rd_data[POS_STATUS]             = status;
   end

endmodule

// File: rtl/pds_timer.sv
module pds_timer #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/pds_fsm.sv
module pds_fsm #(
   parameter int unsigned EXP_W       = 4,
   parameter int unsigned RESTORE_CYC = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_off,
   input  logic                ovr,
   input  logic                ovr_off,
   input  logic [EXP_W-1:0]    exp_clk,
   input  logic [EXP_W-1:0]    exp_few,
   input  logic [EXP_W-1:0]    exp_rest,
   output pds_pkg::pds_state_e st
);
   import pds_pkg::*;

   localparam int unsigned CNT_W = 1 << EXP_W;

   function automatic logic [CNT_W-1:0] span(input logic [EXP_W-1:0] e);
      return (CNT_W'(1) << e) - CNT_W'(1);
   endfunction

   pds_state_e       nxt;
   logic             t_done;
   logic             t_load;
   logic [CNT_W-1:0] t_val;

   always_comb begin
      nxt = st;
      if (ovr) begin
         nxt = ovr_off ? ST_OFF : ST_ON;
      end else begin
         case (st)
            ST_ON:      if (req_off) nxt = ST_CLKOFF;
            ST_CLKOFF:  if (t_done)  nxt = ST_ISO;
            ST_ISO:     if (t_done)  nxt = ST_RESTOFF;
            ST_RESTOFF: if (t_done)  nxt = ST_OFF;
            ST_OFF:     if (!req_off) nxt = ST_FEWON;
            ST_FEWON:   if (t_done)  nxt = ST_RESTON;
            ST_RESTON:  if (t_done)  nxt = ST_RELEASE;
            default:    if (t_done)  nxt = ST_ON;
         endcase
      end
   end

   always_comb begin
      case (nxt)
         ST_CLKOFF:  t_val = span(exp_clk);
         ST_ISO:     t_val = span(exp_rest);
         ST_RESTOFF: t_val = span(exp_few);
         ST_FEWON:   t_val = span(exp_few);
         ST_RESTON:  t_val = span(exp_rest);
         ST_RELEASE: t_val = CNT_W'(RESTORE_CYC - 1);
         default:    t_val = '0;
      endcase
   end

   assign t_load = (nxt != st);

   pds_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .done     (t_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_ON;
      else        st <= nxt;
   end

endmodule

// File: rtl/pwr_domain_seq.sv
module pwr_domain_seq #(
   parameter int unsigned EXP_W       = 4,
   parameter int unsigned REG_W       = 32,
   parameter int unsigned RESTORE_CYC = 4,
   parameter bit          OUT_REG     = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   input  logic             hw_req,
   output logic             clk_en,
   output logic             few_en,
   output logic             rest_en,
   output logic             iso_en,
   output logic             dom_rst,
   output logic             pwr_on
);
   import pds_pkg::*;

   if (EXP_W < 1 || EXP_W > FLD_W) begin : g_bad_exp
      $error("EXP_W must lie between 1 and the 4-bit field width");
   end
   if (REG_W != 32) begin : g_bad_reg
      $error("REG_W must be 32 to hold the status bit position");
   end
   if (RESTORE_CYC < 1 || RESTORE_CYC >= (1 << (1 << EXP_W))) begin : g_bad_rst
      $error("RESTORE_CYC must fit the wait counter and be at least 1");
   end

   logic             collapse, hw_sel, ovr;
   logic [EXP_W-1:0] exp_clk, exp_few, exp_rest;
   logic             req_off;
   logic             status;
   pds_state_e       st;
   pds_drive_t       drv_c, drv_o;
   logic             pwr_c;

   pds_regs #(.EXP_W(EXP_W), .REG_W(REG_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .status   (status),
      .rd_data  (rd_data),
      .collapse (collapse),
      .hw_sel   (hw_sel),
      .ovr      (ovr),
      .exp_clk  (exp_clk),
      .exp_few  (exp_few),
      .exp_rest (exp_rest)
   );

   assign req_off = hw_sel ? hw_req : collapse;

   pds_fsm #(.EXP_W(EXP_W), .RESTORE_CYC(RESTORE_CYC)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_off  (req_off),
      .ovr      (ovr),
      .ovr_off  (collapse),
      .exp_clk  (exp_clk),
      .exp_few  (exp_few),
      .exp_rest (exp_rest),
      .st       (st)
   );

   assign drv_c = ovr ? (collapse ? DRV_OFF : DRV_ON) : pds_decode(st);
   assign pwr_c = ovr ? ~collapse : (st == ST_ON);

   if (OUT_REG) begin : g_out_reg
      pds_drive_t drv_q;
      logic       pwr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            drv_q <= DRV_ON;
            pwr_q <= 1'b1;
         end else begin
            drv_q <= drv_c;
            pwr_q <= pwr_c;
         end
      end
      assign drv_o  = drv_q;
      assign status = pwr_q;
   end else begin : g_out_comb
      assign drv_o  = drv_c;
      assign status = pwr_c;
   end

   assign clk_en  = drv_o.clk_en;
   assign few_en  = drv_o.few_en;
   assign rest_en = drv_o.rest_en;
   assign iso_en  = drv_o.iso_en;
   assign dom_rst = drv_o.dom_rst;
   assign pwr_on  = status;

endmodule

// File: rtl/pds_checker.sv
module pds_checker (
   input logic clk,
   input logic rst_n,
   input logic ovr,
   input logic clk_en,
   input logic few_en,
   input logic rest_en,
   input logic iso_en,
   input logic pwr_on
);

   // R11: the rest group never stands without the few group
   p_rest_needs_few_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rest_en |-> few_en);

   // R11: clocks run only on a fully restored domain
   p_clk_safe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> (few_en && rest_en && !iso_en));

   // R6: status implies a fully restored domain
   p_pwr_on_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_on |-> (clk_en && few_en && rest_en && !iso_en));

   // R3: isolation rises only after clocks are gated
   p_iso_after_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr && $rose(iso_en)) |-> $past(!clk_en));

   // R3: few group falls last, after the rest group is off
   p_few_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr && $fell(few_en)) |-> (!rest_en && $past(!rest_en)));

   // R4: clocks return only after isolation has been released
   p_clk_back_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr && $rose(clk_en)) |-> $past(!iso_en));

endmodule

bind pwr_domain_seq pds_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .ovr     (rd_data[2]),
   .clk_en  (clk_en),
   .few_en  (few_en),
   .rest_en (rest_en),
   .iso_en  (iso_en),
   .pwr_on  (pwr_on)
);

// File: tb/pwr_domain_seq_tb.sv
`timescale 1ns/1ps
module pwr_domain_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        hw_req = 1'b0;
   logic        clk_en, few_en, rest_en, iso_en, dom_rst, pwr_on;
   logic [5:0]  outs;

   int errors = 0;
   int checks = 0;

   // pattern order {clk_en, few_en, rest_en, iso_en, dom_rst, pwr_on}
   localparam logic [5:0] P_ON   = 6'b111001;
   localparam logic [5:0] P_CLK  = 6'b011000;
   localparam logic [5:0] P_ISO  = 6'b011110;
   localparam logic [5:0] P_ROFF = 6'b010110;
   localparam logic [5:0] P_OFF  = 6'b000110;
   localparam logic [5:0] P_FEW  = 6'b010110;
   localparam logic [5:0] P_RON  = 6'b011110;
   localparam logic [5:0] P_REL  = 6'b011000;

   always #2 clk = ~clk;

   pwr_domain_seq u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .hw_req(hw_req), .clk_en(clk_en), .few_en(few_en),
      .rest_en(rest_en), .iso_en(iso_en), .dom_rst(dom_rst), .pwr_on(pwr_on)
   );

   assign outs = {clk_en, few_en, rest_en, iso_en, dom_rst, pwr_on};

   function automatic logic [31:0] mk(input bit col, input bit hw, input bit ov,
                                      input int c, input int r, input int f);
      return (32'(r & 15) << 20) | (32'(f & 15) << 16) | (32'(c & 15) << 12)
           | (32'(ov) << 2) | (32'(hw) << 1) | 32'(col);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic phase(input string req, input string nm, input logic [5:0] pat, input int len);
      int bad = 0;
      logic [5:0] last = pat;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (outs !== pat) begin bad++; last = outs; end
      end
      chk(bad == 0, req, nm, 32'(last), 32'(pat));
   endtask

   task automatic run_down(input int c, input int r, input int f);
      phase("R3", "clock gate step", P_CLK, 1 << c);
      phase("R5", "isolate step", P_ISO, 1 << r);
      phase("R3", "rest off step", P_ROFF, 1 << f);
      phase("R3", "off stable", P_OFF, 3);
      chk(rd_data[31] == 1'b0, "R6", "status after collapse", 32'(rd_data[31]), 32'd0);
   endtask

   task automatic run_up(input int r, input int f);
      phase("R4", "few on step", P_FEW, 1 << f);
      phase("R5", "rest on step", P_RON, 1 << r);
      phase("R4", "release step", P_REL, 4);
      phase("R4", "on stable", P_ON, 3);
      chk(rd_data[31] == 1'b1, "R6", "status after restore", 32'(rd_data[31]), 32'd1);
   endtask

   task automatic cycle_sw(input int c, input int r, input int f);
      wr(mk(1, 0, 0, c, r, f));
      chk(outs === P_ON, "R7", "write lead cycle", 32'(outs), 32'(P_ON));
      run_down(c, r, f);
      wr(mk(0, 0, 0, c, r, f));
      chk(outs === P_OFF, "R7", "restore lead cycle", 32'(outs), 32'(P_OFF));
      run_up(r, f);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data === 32'h8000_0000, "R1", "reset register", rd_data, 32'h8000_0000);
      chk(outs === P_ON, "R1", "reset outputs", 32'(outs), 32'(P_ON));

      // R2 readback: collapse, hw, override kept 0
      wr(32'h7FFF_FFF8);
      chk(rd_data === 32'h80FF_F000, "R2", "register layout", rd_data, 32'h80FF_F000);
      chk(outs === P_ON, "R2", "layout write no action", 32'(outs), 32'(P_ON));

      // R5 directed corners
      cycle_sw(0, 0, 0);
      cycle_sw(1, 1, 15);
      cycle_sw(15, 2, 0);

      // R5 random waits
      for (int k = 0; k < 5; k++) begin
         int c, r, f;
         c = int'($urandom % 5);
         r = int'($urandom % 5);
         f = int'($urandom % 5);
         cycle_sw(c, r, f);
      end

      // R9 reversed request during collapse
      wr(mk(1, 0, 0, 3, 1, 1));
      chk(outs === P_ON, "R9", "lead before pending", 32'(outs), 32'(P_ON));
      wr(mk(0, 0, 0, 3, 1, 1));
      phase("R9", "collapse continues", P_CLK, 6);
      phase("R9", "isolate continues", P_ISO, 2);
      phase("R9", "rest off continues", P_ROFF, 2);
      phase("R9", "single off cycle", P_OFF, 1);
      run_up(1, 1);

      // R8 hardware control
      wr(mk(0, 1, 0, 1, 1, 1));
      wr(mk(1, 1, 0, 1, 1, 1));
      phase("R8", "collapse bit ignored", P_ON, 8);
      @(negedge clk); hw_req = 1'b1;
      chk(outs === P_ON, "R7", "hw lead cycle", 32'(outs), 32'(P_ON));
      run_down(1, 1, 1);
      @(negedge clk); hw_req = 1'b0;
      chk(outs === P_OFF, "R8", "hw restore lead", 32'(outs), 32'(P_OFF));
      run_up(1, 1);
      wr(mk(0, 0, 0, 1, 1, 1));
      phase("R8", "leave hw mode on", P_ON, 4);

      // R10 override
      wr(mk(1, 0, 1, 1, 1, 1));
      chk(outs === P_OFF, "R10", "override off at once", 32'(outs), 32'(P_OFF));
      chk(rd_data[31] == 1'b0, "R6", "override off status", 32'(rd_data[31]), 32'd0);
      phase("R10", "override off hold", P_OFF, 4);
      wr(mk(1, 0, 0, 1, 1, 1));
      phase("R10", "resume off no sequence", P_OFF, 4);
      wr(mk(0, 0, 1, 1, 1, 1));
      chk(outs === P_ON, "R10", "override on at once", 32'(outs), 32'(P_ON));
      wr(mk(0, 0, 0, 1, 1, 1));
      phase("R10", "resume on no sequence", P_ON, 4);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule